// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block produces the active-low system reset of a chip from two sources. The first is a digital supply-good flag from an analog comparator outside the block; it is high while the supply sits above the trip level. The second is the shared open-drain reset line itself, which any other agent on the board may pull low. The block rejects short dips of the supply flag. It holds the line low for a fixed number of clock cycles once the supply is back. It also stretches any low pulse that another agent puts on the line.

The block never drives the line high. It only enables a pull-down, and it reads the wired level back through an input. A falling edge seen on that level while the block is not pulling starts the full timeout. A long external low therefore keeps the line low for as long as the agent holds it. A short one is stretched to the timeout. A write-inhibit flag for the boot memory's write path is raised whenever the block pulls or the line is seen low.

The supply flag and the line level pass through two-flop synchronisers, and all decisions use the synchronised samples. The timeout and the glitch-reject width are parameters counted in clock cycles.

Top module: `supply_reset_seq`

## Requirements
- R1: While `porN` is low, and after it until the supply flag is first seen high, `pullDown` and `writeInhibit` are both 1.
- R2: Once the synchronised supply flag is high after a fault, `pullDown` stays 1 for at least `TIMEOUT_CYCLES` cycles and then goes to 0. With no other activity this happens within `TIMEOUT_CYCLES`+6 cycles of the input rising.
- R3: A low on `supplyGood` that lasts fewer than `GLITCH_CYCLES` clock cycles leaves `pullDown` at 0.
- R4: A low on `supplyGood` that lasts `GLITCH_CYCLES` cycles or more sets `pullDown` to 1 in the cycle after the last of those samples. `pullDown` then stays 1 while the flag remains low.
- R5: A high-to-low change of the synchronised `pinLevel` while `pullDown` is 0 sets `pullDown` to 1 on the next cycle and loads the full timeout.
- R6: An external low shorter than the timeout is stretched. `pullDown` stays 1 for `TIMEOUT_CYCLES` cycles from the detected edge.
- R7: An external low longer than the timeout keeps `writeInhibit` at 1 until the line is seen high again, even though `pullDown` returns to 0 when the timeout ends.
- R8: The low that the block's own pull-down puts on the line never starts a new timeout. After a release with no further stimulus, `pullDown` stays 0.
- R9: A qualifying supply fault during the timeout restarts it. Release comes `TIMEOUT_CYCLES` cycles after the later recovery, not the earlier one.
- R10: `writeInhibit` is 1 whenever `pullDown` is 1 or the synchronised line level is 0, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on initialisation, active low, asynchronous |
| supplyGood | input | 1 | Comparator result, high while the supply is above the trip level (asynchronous) |
| pinLevel | input | 1 | Level read back from the shared open-drain reset line (asynchronous) |
| pullDown | output | 1 | 1 enables the pull-down on the reset line; 0 releases it |
| writeInhibit | output | 1 | 1 blocks the memory write path |

## Verification
The supply flag is driven with dips one cycle shorter than the reject width, dips of exactly the reject width, long outages, and an outage that falls inside a running timeout. Together these separate the filter's threshold, the immediate assertion and the restart of the count. The line is pulled low externally with a pulse much shorter than the timeout and with one much longer. This distinguishes stretching from following the external low and shows the split between `pullDown` and `writeInhibit`. Quiet stretches after each release confirm that the block's own pull never retriggers it. A cycle-accurate behavioural model is compared with both outputs on every clock through all of these patterns.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    ST_FAULT = 2'd0,
    ST_HOLD  = 2'd1,
    ST_RUN   = 2'd2
  } rsqState_e;

  // control -> datapath
  typedef struct packed {
    logic loadTimer;
    logic runTimer;
  } rsqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic faultNow;
    logic extEdge;
    logic timerDone;
  } rsqStatus_t;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             porN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : gBit
    logic stage1, stage2;
    always_ff @(posedge clk or negedge porN) begin
      if (!porN) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= asyncIn[b];
        stage2 <= stage1;
      end
    end
    assign syncOut[b] = stage2;
  end

endmodule

// File: rtl/rsq_datapath.sv
module rsq_datapath
  import rsq_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25_000_000,
  parameter int GLITCH_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       sGood,
  input  logic       sPin,
  input  logic       pullDown,
  input  rsqStrobe_t strobe,
  output rsqStatus_t status
);

  localparam int TW = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam int GW = $clog2(GLITCH_CYCLES + 1);
  localparam logic [TW-1:0] TIMER_LOAD = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [GW-1:0] GLITCH_MAX = GW'(GLITCH_CYCLES);

  logic [GW-1:0] badCnt;
  logic [TW-1:0] timer;
  logic          pinPrev;

  // consecutive low samples of the synchronised supply flag, saturating
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      badCnt <= '0;
    end else if (sGood) begin
      badCnt <= '0;
    end else if (badCnt != GLITCH_MAX) begin
      badCnt <= badCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) pinPrev <= 1'b0;
    else       pinPrev <= sPin;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      timer <= '0;
    end else if (strobe.loadTimer) begin
      timer <= TIMER_LOAD;
    end else if (strobe.runTimer && timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  assign status.faultNow  = (badCnt == GLITCH_MAX);
  assign status.extEdge   = pinPrev & ~sPin & ~pullDown;
  assign status.timerDone = (timer == '0);

endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       porN,
  input  logic       sGood,
  input  rsqStatus_t status,
  output rsqStrobe_t strobe,
  output logic       pullDown
);

  rsqState_e state, stateNext;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_FAULT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext        = state;
    strobe.loadTimer = 1'b0;
    strobe.runTimer  = 1'b0;
    if (status.faultNow) begin
      stateNext = ST_FAULT;
    end else begin
      unique case (state)
        ST_FAULT: if (sGood) begin
          stateNext        = ST_HOLD;
          strobe.loadTimer = 1'b1;
        end
        ST_HOLD: begin
          if (status.timerDone) stateNext = ST_RUN;
          else                  strobe.runTimer = 1'b1;
        end
        ST_RUN: if (status.extEdge) begin
          stateNext        = ST_HOLD;
          strobe.loadTimer = 1'b1;
        end
        default: stateNext = ST_FAULT;
      endcase
    end
  end

  assign pullDown = (state != ST_RUN);

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import rsq_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 25_000_000,
  parameter int GLITCH_CYCLES  = 4
) (
  input  logic clk,
  input  logic porN,
  input  logic supplyGood,
  input  logic pinLevel,
  output logic pullDown,
  output logic writeInhibit
);

  logic [1:0] syncVec;
  logic       sGood;
  logic       sPin;
  rsqStrobe_t strobe;
  rsqStatus_t status;

  rsq_sync #(.WIDTH(2)) uSync (
    .clk    (clk),
    .porN   (porN),
    .asyncIn({pinLevel, supplyGood}),
    .syncOut(syncVec)
  );

  assign sGood = syncVec[0];
  assign sPin  = syncVec[1];

  rsq_datapath #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .GLITCH_CYCLES (GLITCH_CYCLES)
  ) uDp (
    .clk     (clk),
    .porN    (porN),
    .sGood   (sGood),
    .sPin    (sPin),
    .pullDown(pullDown),
    .strobe  (strobe),
    .status  (status)
  );

  rsq_ctrl uCtrl (
    .clk     (clk),
    .porN    (porN),
    .sGood   (sGood),
    .status  (status),
    .strobe  (strobe),
    .pullDown(pullDown)
  );

  assign writeInhibit = pullDown | ~sPin;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int TIMEOUT_CYCLES = 25_000_000,
  parameter int GLITCH_CYCLES  = 4
) (
  input logic clk,
  input logic porN,
  input logic pullDown,
  input logic writeInhibit,
  input logic sGood,
  input logic sPin
);

  localparam int HW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int LW = $clog2(GLITCH_CYCLES + 1);

  logic [HW-1:0] holdCnt;
  logic [LW-1:0] lowRun;
  logic          pinSeen;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      holdCnt <= '0;
      lowRun  <= '0;
      pinSeen <= 1'b0;
    end else begin
      pinSeen <= sPin;
      if (!pullDown) holdCnt <= '0;
      else if (holdCnt != HW'(TIMEOUT_CYCLES)) holdCnt <= holdCnt + 1'b1;
      if (sGood) lowRun <= '0;
      else if (lowRun != LW'(GLITCH_CYCLES)) lowRun <= lowRun + 1'b1;
    end
  end

  AST_FAULT_PULLS: assert property (@(posedge clk) disable iff (!porN)
    (lowRun == LW'(GLITCH_CYCLES)) |=> pullDown); // R4

  AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!porN)
    $fell(pullDown) |-> (holdCnt == HW'(TIMEOUT_CYCLES))); // R2

  AST_RELEASE_SUPPLY_OK: assert property (@(posedge clk) disable iff (!porN)
    $fell(pullDown) |-> (lowRun != LW'(GLITCH_CYCLES))); // R2

  AST_EXT_EDGE_PULLS: assert property (@(posedge clk) disable iff (!porN)
    (pinSeen && !sPin && !pullDown) |=> pullDown); // R5

  AST_INHIBIT_COVERS: assert property (@(posedge clk) disable iff (!porN)
    (pullDown || !sPin) |-> writeInhibit); // R10

  AST_INHIBIT_CLEAR: assert property (@(posedge clk) disable iff (!porN)
    (!pullDown && sPin) |-> !writeInhibit); // R10

endmodule

bind supply_reset_seq rsq_checker #(
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
  .GLITCH_CYCLES (GLITCH_CYCLES)
) uChk (
  .clk         (clk),
  .porN        (porN),
  .pullDown    (pullDown),
  .writeInhibit(writeInhibit),
  .sGood       (sGood),
  .sPin        (sPin)
);

// File: tb/sim_supply_reset_seq.sv
module sim_supply_reset_seq;

  localparam int T = 40;
  localparam int G = 4;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic supplyGood = 1'b0;
  logic extLow = 1'b0;
  logic pinLevel;
  logic pullDown, writeInhibit;

  always #4 clk = ~clk;  // 125 MHz

  assign pinLevel = ~(pullDown | extLow);

  supply_reset_seq #(.TIMEOUT_CYCLES(T), .GLITCH_CYCLES(G)) u0 (
    .clk(clk), .porN(porN), .supplyGood(supplyGood), .pinLevel(pinLevel),
    .pullDown(pullDown), .writeInhibit(writeInhibit)
  );

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  logic sawPull = 1'b0;

  // behavioural reference: 0 fault, 1 timing out, 2 released
  int mState = 0, mCnt = 0, mBad = 0;
  bit g1 = 0, g2 = 0, p1 = 0, p2 = 0, pPrev = 0;
  bit mPull = 1, mInh = 1;

  always @(posedge clk) begin
    if (!porN) begin
      mState = 0; mCnt = 0; mBad = 0;
      g1 = 0; g2 = 0; p1 = 0; p2 = 0; pPrev = 0;
    end else begin
      bit pinNow, fault, edgeSeen;
      int nState, nCnt, nBad;
      pinNow   = !((mState != 2) || extLow);
      fault    = (mBad == G);
      edgeSeen = pPrev && !p2 && (mState == 2);
      nState = mState; nCnt = mCnt;
      if (fault) nState = 0;
      else if (mState == 0) begin
        if (g2) begin nState = 1; nCnt = T - 1; end
      end else if (mState == 1) begin
        if (mCnt == 0) nState = 2; else nCnt = mCnt - 1;
      end else if (edgeSeen) begin
        nState = 1; nCnt = T - 1;
      end
      nBad = g2 ? 0 : ((mBad < G) ? mBad + 1 : G);
      pPrev = p2; p2 = p1; p1 = pinNow;
      g2 = g1; g1 = supplyGood;
      mState = nState; mCnt = nCnt; mBad = nBad;
    end
    mPull = (mState != 2);
    mInh  = mPull || !p2;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (porN) begin
      chk({curReq, " pullDown vs model"}, pullDown, mPull);
      chk({curReq, " writeInhibit vs model (R10)"}, writeInhibit, mInh);
      if (pullDown) sawPull = 1'b1;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 reset pull", pullDown, 1'b1);
    chk("R1 reset inhibit", writeInhibit, 1'b1);
    porN = 1'b1;
    cyc(10);
    chk("R1 supply still bad", pullDown, 1'b1);

    curReq = "R2";
    supplyGood = 1'b1;
    cyc(T);
    chk("R2 held during timeout", pullDown, 1'b1);
    cyc(10);
    chk("R2 released", pullDown, 1'b0);
    chk("R10 inhibit clear", writeInhibit, 1'b0);

    curReq = "R3";
    sawPull = 1'b0;
    supplyGood = 1'b0; cyc(G - 1); supplyGood = 1'b1;
    cyc(20);
    chk("R3 short dip ignored", sawPull, 1'b0);

    curReq = "R4";
    sawPull = 1'b0;
    supplyGood = 1'b0; cyc(G); supplyGood = 1'b1;
    cyc(10);
    chk("R4 dip of reject width", sawPull, 1'b1);
    cyc(T + 10);
    chk("R4 recovered", pullDown, 1'b0);
    supplyGood = 1'b0;
    cyc(G + 4);
    chk("R4 long outage pulls", pullDown, 1'b1);
    cyc(40);
    chk("R4 held while low", pullDown, 1'b1);

    curReq = "R9";
    supplyGood = 1'b1;
    cyc(20);
    supplyGood = 1'b0; cyc(10); supplyGood = 1'b1;
    cyc(T - 5);
    chk("R9 timeout restarted", pullDown, 1'b1);
    cyc(20);
    chk("R9 released after restart", pullDown, 1'b0);

    curReq = "R8";
    sawPull = 1'b0;
    cyc(3 * T);
    chk("R8 no self retrigger after supply release", sawPull, 1'b0);

    curReq = "R5";
    extLow = 1'b1; cyc(3); extLow = 1'b0;
    cyc(4);
    chk("R5 edge pulls", pullDown, 1'b1);
    curReq = "R6";
    cyc(T / 2);
    chk("R6 short pulse stretched", pullDown, 1'b1);
    cyc(T);
    chk("R6 released after timeout", pullDown, 1'b0);

    curReq = "R8";
    sawPull = 1'b0;
    cyc(3 * T);
    chk("R8 no self retrigger after stretch", sawPull, 1'b0);

    curReq = "R7";
    extLow = 1'b1;
    cyc(T + 15);
    chk("R7 pull released at timeout", pullDown, 1'b0);
    chk("R7 inhibit follows line", writeInhibit, 1'b1);
    cyc(15);
    extLow = 1'b0;
    cyc(6);
    chk("R7 inhibit clear after line high", writeInhibit, 1'b0);
    chk("R7 no pull after long low", pullDown, 1'b0);

    cyc(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule